// File: doc/BRIEF.md
# Two-Wire Phase Handshake and Clock Stretch Controller

This block sits between the bit-level shifter of a two-wire serial port and the firmware that runs it. It keeps one pending flag for each completed bus phase: a START driven onto the bus, a byte sent with its acknowledge bit sampled, and a byte shifted into the receive buffer. While any of these flags is pending, the block asks the pad logic to pull the clock line low. The bus therefore stalls until firmware has seen the event and cleared the matching flag with a dedicated strobe.

The block also chooses the acknowledge level for the next received byte. It latches the firmware's negative-acknowledge control bit at the moment the eighth data bit completes, so a late change does not disturb the acknowledge clock. A third duty covers arbitration loss to another master. The block records the loss in a flag that a status read clears. It also moves the port into a not-addressed slave receive state, which lasts until a STOP is seen. In that state the shifter keeps receiving from the byte in which arbitration was lost.

Top module: `twi_phase_hold`

## Requirements
- R1: A one-cycle pulse on `tx_done_i` sets `tx_flag_o` at the next clock edge. The flag stays set until a `fw_clr_tx_i` strobe clears it.
- R2: A pulse on `rx_done_i` sets `rx_flag_o` at the next edge. The flag stays set until a `fw_clr_rx_i` strobe clears it.
- R3: A pulse on `start_sent_i` sets `start_flag_o` at the next edge. The flag stays set until a `fw_clr_start_i` strobe clears it.
- R4: `scl_hold_o` is 1 exactly when at least one of the three phase flags is 1. A clear strobe in cycle n removes its flag, and the hold is released after the edge ending cycle n if no other flag is pending. A clear strobe for one phase leaves the other two flags unchanged.
- R5: When a phase's set pulse and clear strobe arrive in the same cycle, the flag is 1 afterwards, so the new event is kept.
- R6: When `rx_bit8_i` pulses, the value of `nack_sel_i` in that cycle appears on `ack_level_o` after the edge. 1 means NACK (line released) and 0 means ACK (line pulled low).
- R7: While `rx_bit8_i` is 0, changes on `nack_sel_i` leave `ack_level_o` unchanged.
- R8: `arb_lost_i` sets `arb_flag_o` at the next edge, and a `stat_rd_i` strobe clears it. When both arrive in the same cycle, the flag stays set.
- R9: `arb_lost_i` drives `slave_rx_o` to 1 (not-addressed slave receive) at the next edge. `stop_seen_i` returns it to 0, except when `arb_lost_i` arrives in the same cycle, in which case it stays 1.
- R10: `stat_rd_i` has no effect on the transmit, receive and start flags. Only their firmware clear strobes remove them.
- R11: After reset, all four flags, `scl_hold_o`, `ack_level_o` and `slave_rx_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_done_i | input | 1 | Shifter: byte sent and acknowledge sampled |
| rx_done_i | input | 1 | Shifter: received byte loaded into buffer |
| start_sent_i | input | 1 | Shifter: START driven successfully |
| fw_clr_tx_i | input | 1 | Firmware clear strobe for the transmit flag |
| fw_clr_rx_i | input | 1 | Firmware clear strobe for the receive flag |
| fw_clr_start_i | input | 1 | Firmware clear strobe for the start flag |
| stat_rd_i | input | 1 | Status register read strobe |
| rx_bit8_i | input | 1 | Shifter: eighth received bit complete |
| nack_sel_i | input | 1 | Firmware control: 1 answers the next byte with NACK |
| arb_lost_i | input | 1 | Shifter: arbitration lost to another master |
| stop_seen_i | input | 1 | Bus monitor: STOP condition detected |
| tx_flag_o | output | 1 | Transmit phase pending |
| rx_flag_o | output | 1 | Receive phase pending |
| start_flag_o | output | 1 | START phase pending |
| arb_flag_o | output | 1 | Arbitration loss recorded |
| scl_hold_o | output | 1 | Request to pull the clock line low |
| ack_level_o | output | 1 | Acknowledge bit level to drive (1 = NACK) |
| slave_rx_o | output | 1 | Port in not-addressed slave receive state |

## Verification
Every piece of state in this block is a single bit that reaches a port directly. A stuck or lost flag therefore shows on its own output, and on `scl_hold_o`, one edge after the stimulus. The stimulus covers every combination of pending phases against every combination of clear strobes, so a cross-wired clear or a wrong hold term shows up within one cycle of the pattern that exposes it. A latch of the acknowledge level that samples at the wrong time only shows when `nack_sel_i` changes between eighth-bit pulses. For that reason the level is driven to the opposite value between pulses and then checked.

// File: rtl/twi_hold_pkg.sv
package twi_hold_pkg;
   // Index of each phase flag inside the packed phase vectors
   localparam int PH_START = 0;
   localparam int PH_TX    = 1;
   localparam int PH_RX    = 2;
   localparam int NPH      = 3;

   typedef logic [NPH-1:0] phase_vec_t;

   // Arbitration fallback state of the port
   typedef enum logic {
      ROLE_NORMAL   = 1'b0,
      ROLE_SLAVE_RX = 1'b1
   } role_t;
endpackage

// File: rtl/twi_flag_cell.sv
module twi_flag_cell #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q;

   generate
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= set_i | (q & ~clr_i);
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= ~clr_i & (set_i | q);
         end
      end
   endgenerate

   assign q_o = q;

   AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && (SET_WINS || !clr_i)) |=> q_o);          // R5
   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);                        // R4
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !clr_i) |=> q_o);                           // R10
endmodule

// File: rtl/twi_ack_select.sv
module twi_ack_select #(
   parameter bit RESET_NACK = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_i,
   input  logic nack_sel_i,
   output logic ack_level_o
);
   logic lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lvl <= RESET_NACK;
      else if (sample_i) lvl <= nack_sel_i;
   end

   assign ack_level_o = lvl;

   AST_ACK_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
      sample_i |=> (ack_level_o == $past(nack_sel_i)));   // R6
   AST_ACK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_i |=> $stable(ack_level_o));                // R7
endmodule

// File: rtl/twi_arb_track.sv
module twi_arb_track
   import twi_hold_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic arb_lost_i,
   input  logic stat_rd_i,
   input  logic stop_seen_i,
   output logic arb_flag_o,
   output logic slave_rx_o
);
   role_t role_q;
   logic  arb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arb_q  <= 1'b0;
         role_q <= ROLE_NORMAL;
      end else begin
         arb_q <= arb_lost_i | (arb_q & ~stat_rd_i);
         if (arb_lost_i)       role_q <= ROLE_SLAVE_RX;
         else if (stop_seen_i) role_q <= ROLE_NORMAL;
      end
   end

   assign arb_flag_o = arb_q;
   assign slave_rx_o = (role_q == ROLE_SLAVE_RX);

   AST_ARB_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost_i |=> (arb_flag_o && slave_rx_o));         // R8
   AST_ARB_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && !arb_lost_i) |=> !arb_flag_o);        // R8
   AST_SLAVE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_seen_i && !arb_lost_i) |=> !slave_rx_o);      // R9
endmodule

// File: rtl/twi_phase_hold.sv
module twi_phase_hold
   import twi_hold_pkg::*;
#(
   parameter bit         SET_WINS   = 1'b1,
   parameter bit         RESET_NACK = 1'b0,
   parameter logic [2:0] HOLD_MASK  = 3'b111
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_done_i,
   input  logic rx_done_i,
   input  logic start_sent_i,
   input  logic fw_clr_tx_i,
   input  logic fw_clr_rx_i,
   input  logic fw_clr_start_i,
   input  logic stat_rd_i,
   input  logic rx_bit8_i,
   input  logic nack_sel_i,
   input  logic arb_lost_i,
   input  logic stop_seen_i,
   output logic tx_flag_o,
   output logic rx_flag_o,
   output logic start_flag_o,
   output logic arb_flag_o,
   output logic scl_hold_o,
   output logic ack_level_o,
   output logic slave_rx_o
);
   localparam int NHOLD = NPH;

   if (NPH != 3) begin : g_bad_nph
      $error("twi_phase_hold: phase count must be 3");
   end
   if (HOLD_MASK == 3'b000) begin : g_bad_mask
      $error("twi_phase_hold: HOLD_MASK must select at least one phase");
   end

   phase_vec_t ph_set, ph_clr, ph_q, ph_hold;

   assign ph_set[PH_START] = start_sent_i;
   assign ph_set[PH_TX]    = tx_done_i;
   assign ph_set[PH_RX]    = rx_done_i;
   assign ph_clr[PH_START] = fw_clr_start_i;
   assign ph_clr[PH_TX]    = fw_clr_tx_i;
   assign ph_clr[PH_RX]    = fw_clr_rx_i;

   for (genvar i = 0; i < NPH; i++) begin : g_phase
      twi_flag_cell #(.SET_WINS(SET_WINS)) u_flag (
         .clk  (clk),
         .rst_n(rst_n),
         .set_i(ph_set[i]),
         .clr_i(ph_clr[i]),
         .q_o  (ph_q[i])
      );
      if (HOLD_MASK[i]) begin : g_hold_on
         assign ph_hold[i] = ph_q[i];
      end else begin : g_hold_off
         assign ph_hold[i] = 1'b0;
      end
   end

   assign start_flag_o = ph_q[PH_START];
   assign tx_flag_o    = ph_q[PH_TX];
   assign rx_flag_o    = ph_q[PH_RX];
   assign scl_hold_o   = |ph_hold[NHOLD-1:0];

   twi_ack_select #(.RESET_NACK(RESET_NACK)) u_ack (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_i   (rx_bit8_i),
      .nack_sel_i (nack_sel_i),
      .ack_level_o(ack_level_o)
   );

   twi_arb_track u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .arb_lost_i (arb_lost_i),
      .stat_rd_i  (stat_rd_i),
      .stop_seen_i(stop_seen_i),
      .arb_flag_o (arb_flag_o),
      .slave_rx_o (slave_rx_o)
   );

   AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_hold_o) |-> $past(fw_clr_tx_i | fw_clr_rx_i | fw_clr_start_i)); // R4
   AST_TX_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done_i && HOLD_MASK[PH_TX]) |=> (tx_flag_o && scl_hold_o));           // R1
   AST_RX_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done_i && HOLD_MASK[PH_RX]) |=> (rx_flag_o && scl_hold_o));           // R2
   AST_START_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_sent_i && HOLD_MASK[PH_START]) |=> (start_flag_o && scl_hold_o));  // R3
endmodule

// File: tb/sim_twi_phase_hold.sv
module sim_twi_phase_hold;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_done_i = 0, rx_done_i = 0, start_sent_i = 0;
   logic fw_clr_tx_i = 0, fw_clr_rx_i = 0, fw_clr_start_i = 0;
   logic stat_rd_i = 0, rx_bit8_i = 0, nack_sel_i = 0;
   logic arb_lost_i = 0, stop_seen_i = 0;
   logic tx_flag_o, rx_flag_o, start_flag_o, arb_flag_o;
   logic scl_hold_o, ack_level_o, slave_rx_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // expected state; bit 0 = start, bit 1 = tx, bit 2 = rx
   logic [2:0] e_ph = '0;
   logic e_arb = 0, e_srx = 0, e_ack = 0;

   always #4 clk = ~clk;

   twi_phase_hold u0 (
      .clk(clk), .rst_n(rst_n),
      .tx_done_i(tx_done_i), .rx_done_i(rx_done_i), .start_sent_i(start_sent_i),
      .fw_clr_tx_i(fw_clr_tx_i), .fw_clr_rx_i(fw_clr_rx_i), .fw_clr_start_i(fw_clr_start_i),
      .stat_rd_i(stat_rd_i), .rx_bit8_i(rx_bit8_i), .nack_sel_i(nack_sel_i),
      .arb_lost_i(arb_lost_i), .stop_seen_i(stop_seen_i),
      .tx_flag_o(tx_flag_o), .rx_flag_o(rx_flag_o), .start_flag_o(start_flag_o),
      .arb_flag_o(arb_flag_o), .scl_hold_o(scl_hold_o),
      .ack_level_o(ack_level_o), .slave_rx_o(slave_rx_o)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_all(input string req);
      chk({req, " start_flag"}, start_flag_o, e_ph[0]);
      chk({req, " tx_flag"},    tx_flag_o,    e_ph[1]);
      chk({req, " rx_flag"},    rx_flag_o,    e_ph[2]);
      chk({req, " R4 scl_hold"}, scl_hold_o,  |e_ph);
      chk({req, " arb_flag"},   arb_flag_o,   e_arb);
      chk({req, " slave_rx"},   slave_rx_o,   e_srx);
      chk({req, " ack_level"},  ack_level_o,  e_ack);
   endtask

   // Inputs change 2 ns after an edge; results are read 2 ns after the next edge.
   task automatic drive(input logic [2:0] set, input logic [2:0] clr,
                        input logic rd, input logic b8, input logic ns,
                        input logic al, input logic st);
      start_sent_i = set[0]; tx_done_i = set[1]; rx_done_i = set[2];
      fw_clr_start_i = clr[0]; fw_clr_tx_i = clr[1]; fw_clr_rx_i = clr[2];
      stat_rd_i = rd; rx_bit8_i = b8; nack_sel_i = ns;
      arb_lost_i = al; stop_seen_i = st;
      @(posedge clk);
      e_ph  = set | (e_ph & ~clr);
      e_arb = al | (e_arb & ~rd);
      e_srx = al | (e_srx & ~st);
      if (b8) e_ack = ns;
      #2;
      {start_sent_i, tx_done_i, rx_done_i} = '0;
      {fw_clr_start_i, fw_clr_tx_i, fw_clr_rx_i} = '0;
      {stat_rd_i, rx_bit8_i, arb_lost_i, stop_seen_i} = '0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk_all("R11 reset");
      rst_n = 1'b1;
      @(posedge clk); #2;
      chk_all("R11 after release");

      // every pending pattern against every clear pattern
      for (int p = 0; p < 8; p++) begin
         for (int m = 0; m < 8; m++) begin
            drive(p[2:0], 3'b000, 0, 0, nack_sel_i, 0, 0);
            chk_all("R1 R2 R3 set");
            drive(3'b000, 3'b000, 1, 0, nack_sel_i, 0, 0);
            chk_all("R10 status read");
            drive(3'b000, m[2:0], 0, 0, nack_sel_i, 0, 0);
            chk_all("R4 clear");
            drive(3'b000, 3'b111, 0, 0, nack_sel_i, 0, 0);
            chk_all("R4 clear all");
         end
      end

      // simultaneous set and clear, from empty and from pending
      for (int p = 0; p < 8; p++) begin
         for (int pre = 0; pre < 2; pre++) begin
            if (pre == 1) drive(3'b111, 3'b000, 0, 0, nack_sel_i, 0, 0);
            drive(p[2:0], p[2:0], 0, 0, nack_sel_i, 0, 0);
            chk_all("R5 set with clear");
            drive(3'b000, 3'b111, 0, 0, nack_sel_i, 0, 0);
            chk_all("R5 cleanup");
         end
      end

      // acknowledge level sampling
      for (int a = 0; a < 2; a++) begin
         for (int b = 0; b < 2; b++) begin
            drive(3'b000, 3'b000, 0, 1, a[0], 0, 0);
            chk_all("R6 sample");
            drive(3'b000, 3'b000, 0, 0, ~a[0], 0, 0);
            chk_all("R7 no sample");
            drive(3'b000, 3'b000, 0, 0, b[0], 0, 0);
            chk_all("R7 no sample again");
            drive(3'b000, 3'b000, 0, 1, b[0], 0, 0);
            chk_all("R6 resample");
         end
      end

      // arbitration loss and slave fallback, all combos of the three strobes
      for (int pre = 0; pre < 2; pre++) begin
         for (int c = 0; c < 8; c++) begin
            if (pre == 1) begin
               drive(3'b000, 3'b000, 0, 0, nack_sel_i, 1, 0);
               chk_all("R8 R9 enter");
            end
            drive(3'b000, 3'b000, c[1], 0, nack_sel_i, c[0], c[2]);
            chk_all("R8 R9 combo");
            drive(3'b000, 3'b000, 1, 0, nack_sel_i, 0, 1);
            chk_all("R8 R9 exit");
         end
      end

      // arbitration loss while phases are pending leaves them untouched
      drive(3'b110, 3'b000, 0, 0, nack_sel_i, 1, 0);
      chk_all("R10 arb with pending");
      drive(3'b000, 3'b000, 1, 0, nack_sel_i, 0, 1);
      chk_all("R10 read with pending");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule